// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple synchronous host port and an external asynchronous static RAM that is 16 bits wide. The host presents one request at a time. Each request carries a word address, write data, a per-byte lane mask and a read/write flag. The controller then plays out the matching pin-level cycle on the memory pins. Every phase of that cycle lasts a whole number of system clocks. When the cycle finishes, the controller pulses a completion flag for one clock, and on reads it presents the captured data at the same time.

Every memory pin comes straight from a flop, so the pins change only at clock edges and never glitch. The memory is selected only while the active-low chip enable is low and the active-high chip enable is high.

A write opens with an address setup phase. A write-enable pulse follows, and a hold phase comes after it. Output enable stays high for the whole write. The data bus stays undriven for a programmable number of clocks after write enable falls, so a device whose outputs are still switching off is never fought. A read holds output enable low for a fixed access time and latches the bus on the last clock of that time. Byte lanes the host did not request come back as zero.

The bidirectional data bus is brought out as separate output data, output-enable and input data ports. The chip-level pad ring joins them.

Top module: `sram_ctl`

## Requirements
- R1: During reset, while idle, and in the cycle that carries the completion pulse, the memory is parked in the deselected state: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, both bits of `mem_be_n`=1 and `mem_dq_oe`=0.
- R2: A write accepted at clock edge k occupies the next T_AS cycles with the memory selected, `mem_we_n`=1 and `mem_oe_n`=1. The next T_WP cycles have `mem_we_n`=0. The T_DH cycles after that have `mem_we_n`=1 with the memory still selected, before it returns to idle.
- R3: `mem_dq_oe` is 1 only in pulse cycles whose index within the pulse (counting from 0) is at least T_TURN, and in every hold cycle. It is never 1 while `mem_oe_n`=0 or while the memory is deselected. `mem_dq_o` holds the request's write data throughout, which gives at least T_WP−T_TURN driven clocks before write enable rises.
- R4: Throughout a cycle, `mem_be_n[i]` = NOT `host_be[i]`, where lane 0 is data bits 7:0 and lane 1 is bits 15:8. A single-byte request asserts only that lane's enable.
- R5: A read accepted at edge k holds the memory selected with `mem_oe_n`=0 and `mem_we_n`=1 for the next T_RD cycles. `host_rdata` is loaded from `mem_dq_i` at the edge that ends the last of these cycles. Lanes whose `host_be` bit was 0 read as 0.
- R6: `host_done` is 1 for exactly one cycle, the one right after the last phase of a read or write. On reads, `host_rdata` is valid in that cycle.
- R7: `host_req` is acted on only at an edge where the controller is idle, and the completion cycle counts as idle. A request raised while a cycle is in progress has no effect on the pins.
- R8: `mem_addr` holds the accepted address for the whole cycle. Address and byte enables never change while `mem_we_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronous to clk |
| host_req | input | 1 | Request strobe, sampled when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | DATA_W/8 | Lane mask, 1 = lane used; bit 0 = bits 7:0 |
| host_rdata | output | DATA_W | Read data, valid with host_done |
| host_done | output | 1 | One-clock completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DATA_W/8 | Lane enables, active low; bit 0 = lower byte |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
The bench builds the controller with T_AS=2, T_WP=3, T_TURN=1, T_DH=2 and T_RD=4, keeping the full 21-bit address and 16-bit data. These values avoid the default single-clock setup and hold, so the phase counter wraps inside every phase. The one-clock turn-off gap leaves exactly two driven clocks before write enable rises, which makes an off-by-one in bus drive or setup count visible. The top address, single-lane writes and reads on both lanes, a request raised mid-cycle and requests issued back to back in the completion cycle are all reachable with these values.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSET = 3'd1,
    PH_WPUL = 3'd2,
    PH_WHLD = 3'd3,
    PH_RACC = 3'd4
  } phase_e;

endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  logic cnt_en;

  always_comb begin
    if (!run || restart) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = run | (|cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int T_AS  = 1,
  parameter int T_WP  = 4,
  parameter int T_DH  = 1,
  parameter int T_RD  = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr,
  input  logic [CNT_W-1:0] cnt_q,
  output phase_e           phase_d,
  output logic             accept,
  output logic             last,
  output logic             done_d,
  output logic             capture
);

  phase_e phase_q;

  function automatic logic [CNT_W-1:0] ph_end(input phase_e p);
    case (p)
      PH_WSET: return CNT_W'(T_AS - 1);
      PH_WPUL: return CNT_W'(T_WP - 1);
      PH_WHLD: return CNT_W'(T_DH - 1);
      PH_RACC: return CNT_W'(T_RD - 1);
      default: return '0;
    endcase
  endfunction

  assign last = (phase_q != PH_IDLE) && (cnt_q == ph_end(phase_q));

  always_comb begin
    phase_d = phase_q;
    accept  = 1'b0;
    done_d  = 1'b0;
    capture = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          phase_d = wr ? PH_WSET : PH_RACC;
        end
      end
      PH_WSET: if (last) phase_d = PH_WPUL;
      PH_WPUL: if (last) phase_d = PH_WHLD;
      PH_WHLD: begin
        if (last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      PH_RACC: begin
        if (last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          capture = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int T_TURN = 1,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_d,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              accept,
  input  logic              capture,
  input  logic              done_d,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  localparam logic [CNT_W-1:0] TURN_C = CNT_W'(T_TURN);

  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_src;
  logic             sel_d;
  logic             drive_d;

  assign be_src  = accept ? host_be : be_q;
  assign sel_d   = (phase_d != PH_IDLE);
  assign drive_d = ((phase_d == PH_WPUL) && (cnt_d >= TURN_C)) ||
                   (phase_d == PH_WHLD);

  // request holding registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
      be_q     <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      mem_dq_o <= host_wdata;
      be_q     <= host_be;
    end
  end

  // control pins registered from the next phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      host_done <= 1'b0;
    end else begin
      mem_ce_n  <= ~sel_d;
      mem_ce    <= sel_d;
      mem_we_n  <= ~(phase_d == PH_WPUL);
      mem_oe_n  <= ~(phase_d == PH_RACC);
      mem_dq_oe <= drive_d;
      host_done <= done_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_be_n[l] <= 1'b1;
      else        mem_be_n[l] <= ~(sel_d & be_src[l]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       host_rdata[l*8 +: 8] <= '0;
      else if (capture) host_rdata[l*8 +: 8] <= be_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int T_AS   = 1,
  parameter int T_WP   = 4,
  parameter int T_TURN = 1,
  parameter int T_DH   = 1,
  parameter int T_RD   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic                  host_wr,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     host_wdata,
  input  logic [DATA_W/8-1:0]   host_be,
  output logic [DATA_W-1:0]     host_rdata,
  output logic                  host_done,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_ce,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);

  localparam int LANES  = DATA_W / 8;
  localparam int MAX_W  = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int MAX_H  = (T_DH > T_RD) ? T_DH : T_RD;
  localparam int MAXLEN = (MAX_W > MAX_H) ? MAX_W : MAX_H;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             accept;
  logic             last;
  logic             done_d;
  logic             capture;

  sram_ctl_fsm #(
    .T_AS (T_AS),
    .T_WP (T_WP),
    .T_DH (T_DH),
    .T_RD (T_RD),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (host_req),
    .wr     (host_wr),
    .cnt_q  (cnt_q),
    .phase_d(phase_d),
    .accept (accept),
    .last   (last),
    .done_d (done_d),
    .capture(capture)
  );

  sram_ctl_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (phase_d != PH_IDLE),
    .restart(accept | last),
    .cnt_q  (cnt_q),
    .cnt_d  (cnt_d)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES),
    .T_TURN(T_TURN),
    .CNT_W (CNT_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_d   (phase_d),
    .cnt_d     (cnt_d),
    .accept    (accept),
    .capture   (capture),
    .done_d    (done_d),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_be   (host_be),
    .mem_dq_i  (mem_dq_i),
    .host_rdata(host_rdata),
    .host_done (host_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_done,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_ce_n,
  input logic                mem_ce,
  input logic                mem_we_n,
  input logic                mem_oe_n,
  input logic [DATA_W/8-1:0] mem_be_n,
  input logic [DATA_W-1:0]   mem_dq_o,
  input logic                mem_dq_oe
);

  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R3

  AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_ce)); // R3

  AST_DRIVE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R3

  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n); // R5

  AST_ADDR_STABLE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_be_n))); // R8

  AST_DESELECT_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done); // R6

  AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n &&
                   (mem_be_n == '1) && !mem_dq_oe)); // R1

  AST_CE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n == !mem_ce); // R1

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_done(host_done),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_ce   (mem_ce),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_be_n (mem_be_n),
  .mem_dq_o (mem_dq_o),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

  localparam int AW  = 21;
  localparam int DW  = 16;
  localparam int TAS = 2;
  localparam int TWP = 3;
  localparam int TTN = 1;
  localparam int TDH = 2;
  localparam int TRD = 4;
  localparam logic [AW-1:0] AMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_req;
  logic          host_wr;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic [1:0]    host_be;
  logic [DW-1:0] host_rdata;
  logic          host_done;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_o;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_i;

  always #4 clk = ~clk;

  sram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .T_AS(TAS), .T_WP(TWP),
    .T_TURN(TTN), .T_DH(TDH), .T_RD(TRD)
  ) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_rdata(host_rdata), .host_done(host_done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  typedef struct {
    bit          sel;
    bit          we_n;
    bit          oe_n;
    bit          dq_oe;
    bit          done;
    bit [1:0]    be_n;
    bit [AW-1:0] addr;
    bit [DW-1:0] dq;
    bit          rd_chk;
    bit [DW-1:0] rexp;
  } exp_t;

  exp_t          expq[$];
  logic [DW-1:0] shadow [int unsigned];
  logic [DW-1:0] model  [int unsigned];
  int            n_run  = 0;
  int            n_fail = 0;
  bit            idle_now = 1'b1;
  bit            acc_pulse = 1'b0;
  bit            prev_we_n = 1'b1;
  int            ds_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [DW-1:0] sh_rd(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  // reference schedule: built at the accepting edge
  always @(posedge clk) begin
    acc_pulse = 1'b0;
    if (rst_n && idle_now && host_req) begin
      exp_t e;
      acc_pulse = 1'b1;
      e = '{default: 0};
      e.sel = 1; e.be_n = ~host_be; e.addr = host_addr; e.dq = host_wdata;
      if (host_wr) begin
        e.we_n = 1; e.oe_n = 1;
        for (int i = 0; i < TAS; i++) expq.push_back(e);
        for (int i = 0; i < TWP; i++) begin
          e.we_n = 0; e.dq_oe = (i >= TTN); expq.push_back(e);
        end
        e.we_n = 1; e.dq_oe = 1;
        for (int i = 0; i < TDH; i++) expq.push_back(e);
        shadow[host_addr] = (sh_rd(host_addr) & ~lane_mask(host_be)) |
                            (host_wdata & lane_mask(host_be));
        e = '{default: 0}; e.we_n = 1; e.oe_n = 1; e.be_n = 2'b11; e.done = 1;
        expq.push_back(e);
      end else begin
        e.we_n = 1; e.oe_n = 0;
        for (int i = 0; i < TRD; i++) expq.push_back(e);
        e = '{default: 0}; e.we_n = 1; e.oe_n = 1; e.be_n = 2'b11; e.done = 1;
        e.rd_chk = 1; e.rexp = sh_rd(host_addr) & lane_mask(host_be);
        expq.push_back(e);
      end
    end
  end

  // per-clock comparison, pin-level memory model, contention watch
  always @(negedge clk) begin
    if (!rst_n) begin
      idle_now = 1'b1;
      mem_dq_i = '0;
    end else begin
      exp_t e;
      bit   sel, drv;
      logic [DW-1:0] rv;
      if (expq.size() > 0) e = expq.pop_front();
      else begin
        e = '{default: 0}; e.we_n = 1; e.oe_n = 1; e.be_n = 2'b11;
      end
      idle_now = !e.sel;
      sel = !mem_ce_n && mem_ce;
      chk(mem_ce_n == !e.sel && mem_ce == e.sel, "R1 select", {mem_ce_n, mem_ce}, {!e.sel, e.sel});
      chk(mem_we_n == e.we_n, "R2 we_n", mem_we_n, e.we_n);
      chk(mem_dq_oe == e.dq_oe, "R3 dq_oe", mem_dq_oe, e.dq_oe);
      chk(mem_be_n == e.be_n, "R4 be_n", mem_be_n, e.be_n);
      chk(mem_oe_n == e.oe_n, "R5 oe_n", mem_oe_n, e.oe_n);
      chk(host_done == e.done, "R6 done", host_done, e.done);
      if (e.sel)   chk(mem_addr == e.addr, "R8 addr", mem_addr, e.addr);
      if (e.dq_oe) chk(mem_dq_o == e.dq, "R3 write data", mem_dq_o, e.dq);
      if (e.rd_chk) chk(host_rdata == e.rexp, "R5 read data", host_rdata, e.rexp);

      // memory model: capture on write-enable rising edge
      if (!mem_we_n && mem_dq_oe) ds_cnt++;
      if (!prev_we_n && mem_we_n && sel) begin
        logic [DW-1:0] old;
        chk(ds_cnt >= TWP - TTN, "R3 data setup", ds_cnt, TWP - TTN);
        chk(mem_dq_oe, "R3 data hold", mem_dq_oe, 1);
        old = model.exists(mem_addr) ? model[mem_addr] : '0;
        if (!mem_be_n[0]) old[7:0]  = mem_dq_o[7:0];
        if (!mem_be_n[1]) old[15:8] = mem_dq_o[15:8];
        model[mem_addr] = old;
        ds_cnt = 0;
      end
      if (mem_we_n) ds_cnt = 0;
      prev_we_n = mem_we_n;

      drv = sel && mem_we_n && !mem_oe_n && (mem_be_n != 2'b11);
      rv  = model.exists(mem_addr) ? model[mem_addr] : '0;
      mem_dq_i = '0;
      if (sel && mem_we_n && !mem_oe_n) begin
        if (!mem_be_n[0]) mem_dq_i[7:0]  = rv[7:0];
        if (!mem_be_n[1]) mem_dq_i[15:8] = rv[15:8];
      end
      if (drv && mem_dq_oe) chk(1'b0, "R3 bus contention", 1, 0);
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [1:0] be);
    host_req = 1; host_wr = wr; host_addr = a; host_wdata = d; host_be = be;
    do begin
      @(posedge clk); #2;
    end while (!acc_pulse);
    host_req = 0;
  endtask

  task automatic drain();
    while (expq.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    rst_n = 0; host_req = 0; host_wr = 0; host_addr = '0;
    host_wdata = '0; host_be = 2'b00; mem_dq_i = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: parked pins while in reset
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_be_n == 2'b11 &&
        !mem_dq_oe && !host_done, "R1 reset park",
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, host_done},
        8'b1011_1100);
    host_req = 1; host_wr = 1;   // R7: request during reset must be ignored
    @(posedge clk); #2;
    host_req = 0;
    rst_n = 1;
    repeat (3) @(posedge clk);
    #2;

    // R2 R4: full-word writes, including the lowest and highest address
    issue(1, '0, 16'h1234, 2'b11);
    issue(1, AMAX, 16'hA5C3, 2'b11);
    issue(1, 21'd5, 16'hBEEF, 2'b11);
    // R4: single-lane writes, back to back in the completion cycle (R7)
    issue(1, 21'd5, 16'h0011, 2'b01);
    issue(1, 21'd5, 16'h2200, 2'b10);
    // R5: reads, full and per lane
    issue(0, 21'd5, '0, 2'b11);
    issue(0, '0, '0, 2'b11);
    issue(0, AMAX, '0, 2'b01);
    issue(0, AMAX, '0, 2'b10);
    issue(0, 21'd100, '0, 2'b11);
    drain();

    // R7: a request raised mid-cycle has no effect
    issue(1, 21'd9, 16'h7777, 2'b11);
    @(posedge clk); #2;
    host_req = 1; host_wr = 0; host_addr = 21'h0ABCD; host_be = 2'b11;
    @(posedge clk); #2;
    host_req = 0;
    drain();
    issue(0, 21'd9, '0, 2'b11);
    // alternating read/write back to back
    issue(1, 21'h155555, 16'h5AA5, 2'b11);
    issue(0, 21'h155555, '0, 2'b11);
    issue(1, 21'h155555, 16'h00FF, 2'b10);
    issue(0, 21'h155555, '0, 2'b11);
    drain();
    summary();
  end

endmodule